// File: doc/BRIEF.md
# Process ID address relocation unit

This block keeps a 7-bit process identifier in a control register. It uses that identifier to move low virtual addresses into a per-process region before they reach the caches and the memory management unit. Software sets the identifier through a simple register write strobe and reads it back through a read strobe.

The block has two address ports. One serves instruction fetches and has a fetch strobe. The other serves data accesses. An address whose top seven bits are all zero lies in the lowest 32MB window. For such an address, those seven bits are replaced with the identifier, so that process N sees its low 32MB at N times 32MB. Any other address passes through unchanged. Translation is combinational on both ports.

A new identifier does not take effect at once. Two further instruction fetches after the write still use the old value. The new value is committed at the clock edge that ends the second of those fetches. From then on, both ports use it.

Top module: `pid_reloc_unit`

## Requirements
- R1: After reset, the effective and the programmed identifier are both zero. A read returns 0, and every address on both ports passes through unchanged.
- R2: A write (reg_wr high at a clock edge) takes the new identifier from reg_wdata[31:25]. Bits [24:0] of the write data have no effect on the stored identifier or on translation.
- R3: While reg_rd is high, reg_rdata shows the last written identifier in bits [31:25], in the same cycle, with bits [24:0] zero. While reg_rd is low, reg_rdata is all zero.
- R4: An address with bits [31:25] equal to zero is output as {effective identifier, address[24:0]}, which is the address plus identifier times 32MB.
- R5: An address with any of bits [31:25] set is output unchanged.
- R6: With an effective identifier of zero, every address is output unchanged.
- R7: A fetch strobe in the write cycle is not counted. The first two fetch cycles after the write translate with the old identifier, and the third and later fetches use the new one.
- R8: The data port and the fetch port always translate with the same effective identifier, so equal inputs give equal outputs.
- R9: A second write while an update is pending replaces the pending value and restarts the two-fetch count. A value that is replaced in this way never takes effect.
- R10: Without fetch strobes, a pending identifier never takes effect, however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; identifier in [31:25] |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data; identifier in [31:25] |
| if_req | input | 1 | Instruction fetch strobe |
| if_vaddr | input | 32 | Fetch virtual address |
| if_paddr | output | 32 | Fetch relocated address |
| dt_vaddr | input | 32 | Data virtual address |
| dt_paddr | output | 32 | Data relocated address |

## Verification
The bench targets the exact fetch on which a new identifier appears:
- A design that counts the fetch in the write cycle, or commits one fetch early or late, shows a wrong top address byte on the second or third fetch.
- A design that keeps the first count after a second write lets an overwritten identifier show up briefly.
- A design that counts clock cycles instead of fetches commits during idle gaps.

The window edges are also driven:
- The addresses 0x01FFFFFF and 0x02000000 expose a window comparison that is off by one bit.
- Write data with noisy low bits exposes a design that stores or reflects bits [24:0].

// File: rtl/pid_reloc_pkg.sv
package pid_reloc_pkg;

   typedef enum logic {
      UPD_IDLE = 1'b0,
      UPD_WAIT = 1'b1
   } upd_state_e;

   function automatic int unsigned cnt_bits(input int unsigned lag);
      int unsigned w;
      w = 1;
      while ((1 << w) <= lag) w++;
      return w;
   endfunction

endpackage

// File: rtl/pid_id_ctrl.sv
module pid_id_ctrl
   import pid_reloc_pkg::*;
#(
   parameter int unsigned PID_W     = 7,
   parameter int unsigned FETCH_LAG = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PID_W-1:0] wr_id,
   input  logic             fetch_stb,
   output logic [PID_W-1:0] eff_id,
   output logic [PID_W-1:0] prog_id
);

   localparam int unsigned CNT_W = cnt_bits(FETCH_LAG);

   generate
      if (FETCH_LAG == 0) begin : g_direct
         logic [PID_W-1:0] id_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_q <= '0;
            end else if (wr_en) begin
               id_q <= wr_id;
            end
         end

         assign eff_id  = id_q;
         assign prog_id = id_q;
      end else begin : g_delayed
         upd_state_e       st_q;
         logic [PID_W-1:0] eff_q;
         logic [PID_W-1:0] pend_q;
         logic [CNT_W-1:0] cnt_q;
         logic             last_fetch;

         assign last_fetch = (st_q == UPD_WAIT) && fetch_stb && (cnt_q == CNT_W'(1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q   <= UPD_IDLE;
               eff_q  <= '0;
               pend_q <= '0;
               cnt_q  <= '0;
            end else if (wr_en) begin
               st_q   <= UPD_WAIT;
               pend_q <= wr_id;
               cnt_q  <= CNT_W'(FETCH_LAG);
            end else if (last_fetch) begin
               st_q  <= UPD_IDLE;
               eff_q <= pend_q;
               cnt_q <= '0;
            end else if ((st_q == UPD_WAIT) && fetch_stb) begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end

         assign eff_id  = eff_q;
         assign prog_id = (st_q == UPD_WAIT) ? pend_q : eff_q;
      end
   endgenerate

endmodule

// File: rtl/pid_addr_map.sv
module pid_addr_map #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PID_W  = 7
) (
   input  logic [PID_W-1:0]  id,
   input  logic [ADDR_W-1:0] vaddr,
   output logic [ADDR_W-1:0] paddr
);

   localparam int unsigned WIN_W = ADDR_W - PID_W;

   logic in_window;

   assign in_window = (vaddr[ADDR_W-1:WIN_W] == '0);

   always_comb begin
      paddr = vaddr;
      if (in_window) begin
         paddr[ADDR_W-1:WIN_W] = id;
      end
   end

endmodule

// File: rtl/pid_rd_port.sv
module pid_rd_port #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PID_W  = 7
) (
   input  logic              rd_en,
   input  logic [PID_W-1:0]  id,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned PAD_W = DATA_W - PID_W;

   assign rdata = rd_en ? {id, {PAD_W{1'b0}}} : '0;

endmodule

// File: rtl/pid_reloc_unit.sv
module pid_reloc_unit #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PID_W     = 7,
   parameter int unsigned FETCH_LAG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              if_req,
   input  logic [ADDR_W-1:0] if_vaddr,
   output logic [ADDR_W-1:0] if_paddr,
   input  logic [ADDR_W-1:0] dt_vaddr,
   output logic [ADDR_W-1:0] dt_paddr
);

   localparam int unsigned WIN_W = ADDR_W - PID_W;

   generate
      if (PID_W < 1 || PID_W >= ADDR_W) begin : g_bad_pid_w
         $error("pid_reloc_unit: PID_W must be between 1 and ADDR_W-1");
      end
      if (FETCH_LAG > 15) begin : g_bad_lag
         $error("pid_reloc_unit: FETCH_LAG out of supported range");
      end
   endgenerate

   logic [PID_W-1:0] eff_id;
   logic [PID_W-1:0] prog_id;

   pid_id_ctrl #(
      .PID_W     (PID_W),
      .FETCH_LAG (FETCH_LAG)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .wr_id     (reg_wdata[ADDR_W-1:WIN_W]),
      .fetch_stb (if_req),
      .eff_id    (eff_id),
      .prog_id   (prog_id)
   );

   pid_addr_map #(
      .ADDR_W (ADDR_W),
      .PID_W  (PID_W)
   ) u_map_if (
      .id    (eff_id),
      .vaddr (if_vaddr),
      .paddr (if_paddr)
   );

   pid_addr_map #(
      .ADDR_W (ADDR_W),
      .PID_W  (PID_W)
   ) u_map_dt (
      .id    (eff_id),
      .vaddr (dt_vaddr),
      .paddr (dt_paddr)
   );

   pid_rd_port #(
      .DATA_W (ADDR_W),
      .PID_W  (PID_W)
   ) u_rd (
      .rd_en (reg_rd),
      .id    (prog_id),
      .rdata (reg_rdata)
   );

endmodule

// File: rtl/pid_reloc_chk.sv
module pid_reloc_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PID_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_wdata,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_rdata,
   input logic              if_req,
   input logic [ADDR_W-1:0] if_vaddr,
   input logic [ADDR_W-1:0] if_paddr,
   input logic [ADDR_W-1:0] dt_vaddr,
   input logic [ADDR_W-1:0] dt_paddr,
   input logic [PID_W-1:0]  eff_id
);

   localparam int unsigned WIN_W = ADDR_W - PID_W;

   p_ports_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (if_vaddr == dt_vaddr) |-> (if_paddr == dt_paddr));

   p_high_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_vaddr[ADDR_W-1:WIN_W] != '0) |-> (dt_paddr == dt_vaddr));

   p_rd_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> (reg_rdata[WIN_W-1:0] == '0));

   p_rd_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |-> (reg_rdata == '0));

   p_no_fetch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && !if_req) |=> $stable(eff_id));

   p_wr_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> $stable(eff_id));

   p_rd_after_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && $past(reg_wr)) |-> (reg_rdata[ADDR_W-1:WIN_W] == $past(reg_wdata[ADDR_W-1:WIN_W])));

endmodule

bind pid_reloc_unit pid_reloc_chk #(
   .ADDR_W (ADDR_W),
   .PID_W  (PID_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rd    (reg_rd),
   .reg_rdata (reg_rdata),
   .if_req    (if_req),
   .if_vaddr  (if_vaddr),
   .if_paddr  (if_paddr),
   .dt_vaddr  (dt_vaddr),
   .dt_paddr  (dt_paddr),
   .eff_id    (eff_id)
);

// File: tb/sim_pid_reloc_unit.sv
module sim_pid_reloc_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic        if_req = 1'b0;
   logic [31:0] if_vaddr = '0;
   logic [31:0] if_paddr;
   logic [31:0] dt_vaddr = '0;
   logic [31:0] dt_paddr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pid_reloc_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata),
      .if_req    (if_req),
      .if_vaddr  (if_vaddr),
      .if_paddr  (if_paddr),
      .dt_vaddr  (dt_vaddr),
      .dt_paddr  (dt_paddr)
   );

   // {id[6:0], vaddr[31:0], expected paddr[31:0]}
   localparam logic [70:0] VEC [8] = '{
      {7'h00, 32'h0123_4567, 32'h0123_4567},
      {7'h01, 32'h0000_1000, 32'h0200_1000},
      {7'h7F, 32'h01FF_FFFF, 32'hFFFF_FFFF},
      {7'h55, 32'h0000_0000, 32'hAA00_0000},
      {7'h55, 32'h0200_0000, 32'h0200_0000},
      {7'h2A, 32'h8000_0004, 32'h8000_0004},
      {7'h2A, 32'h0100_0000, 32'h5500_0000},
      {7'h01, 32'hFE00_0000, 32'hFE00_0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr_id(input logic [6:0] id);
      reg_wr    = 1'b1;
      reg_wdata = {id, 25'h155_5555};
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic fetch(input string req, input logic [31:0] va, input logic [31:0] exp);
      if_req   = 1'b1;
      if_vaddr = va;
      #1;
      check(req, if_paddr, exp);
      @(negedge clk);
      if_req = 1'b0;
   endtask

   task automatic fetch_n(input int n);
      for (int i = 0; i < n; i++) begin
         if_req   = 1'b1;
         if_vaddr = 32'h0000_0040;
         @(negedge clk);
      end
      if_req = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [31:0] exp);
      reg_rd = 1'b1;
      #1;
      check(req, reg_rdata, exp);
      reg_rd = 1'b0;
   endtask

   task automatic data_check(input string req, input logic [31:0] va, input logic [31:0] exp);
      dt_vaddr = va;
      #1;
      check(req, dt_paddr, exp);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      rd_check("R1 read after reset", 32'h0);
      data_check("R1 data flat in reset", 32'h0123_4567, 32'h0123_4567);
      rst_n = 1'b1;
      @(negedge clk);
      data_check("R1 data flat after reset", 32'h0000_0100, 32'h0000_0100);
      fetch("R1 fetch flat after reset", 32'h01FF_FFFF, 32'h01FF_FFFF);
      reg_rd = 1'b0;
      #1 check("R3 idle read zero", reg_rdata, 32'h0);

      // Vector table: R4 R5 R6 R2
      foreach (VEC[k]) begin
         wr_id(VEC[k][70:64]);
         rd_check("R3 read last written", {VEC[k][70:64], 25'h0});
         fetch_n(2);
         data_check("R4/R5/R6 data table", VEC[k][63:32], VEC[k][31:0]);
         fetch("R4/R5/R6 fetch table", VEC[k][63:32], VEC[k][31:0]);
      end

      // R7: exact switch point; write-cycle fetch not counted
      wr_id(7'h03);
      fetch_n(2);
      if_req   = 1'b1;
      reg_wr   = 1'b1;
      reg_wdata = {7'h11, 25'h1FF_FFFF};
      if_vaddr = 32'h0000_0010;
      @(negedge clk);
      reg_wr = 1'b0;
      fetch("R7 fetch 1 old id", 32'h0000_0010, 32'h0600_0010);
      data_check("R8 data old id", 32'h0000_0020, 32'h0600_0020);
      fetch("R7 fetch 2 old id", 32'h0000_0010, 32'h0600_0010);
      fetch("R7 fetch 3 new id", 32'h0000_0010, 32'h2200_0010);
      data_check("R8 data new id", 32'h0000_0020, 32'h2200_0020);
      check("R2 low bits ignored", dt_paddr[24:0], 25'h000_0020);

      // R9: rewrite while pending
      wr_id(7'h40);
      fetch("R9 pending A old", 32'h0, 32'h2200_0000);
      wr_id(7'h05);
      rd_check("R9 read replaced", {7'h05, 25'h0});
      fetch("R9 restart fetch 1", 32'h0, 32'h2200_0000);
      fetch("R9 restart fetch 2", 32'h0, 32'h2200_0000);
      fetch("R9 B takes effect", 32'h0, 32'h0A00_0000);

      // R10: idle cycles do not commit
      wr_id(7'h7E);
      repeat (20) @(negedge clk);
      data_check("R10 no commit while idle", 32'h0000_0008, 32'h0A00_0008);
      fetch("R10 first fetch after idle", 32'h0000_0008, 32'h0A00_0008);
      fetch("R10 second fetch after idle", 32'h0000_0008, 32'h0A00_0008);
      fetch("R10 commit after two fetches", 32'h0000_0008, 32'hFC00_0008);

      // R6 back to flat, R5 boundary
      wr_id(7'h00);
      fetch_n(2);
      data_check("R6 flat id zero", 32'h01FF_FFFF, 32'h01FF_FFFF);
      wr_id(7'h7F);
      fetch_n(2);
      data_check("R5 boundary 32MB", 32'h0200_0000, 32'h0200_0000);

      // R1: reset mid run
      rst_n = 1'b0;
      #1;
      rd_check("R1 read during reset", 32'h0);
      data_check("R1 flat during reset", 32'h0000_0004, 32'h0000_0004);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule